// File: doc/BRIEF.md
# CAS-before-RAS Refresh Scheduler

This block keeps an EDO DRAM array refreshed without the memory controller having to supply row addresses. A free-running interval timer marks each slot in which one refresh is owed and adds it to a small pending counter. While anything is pending, the block holds a request toward the memory arbiter. When the arbiter grants the bus, the block drives the refresh strobe pattern: column strobe low first, then row strobe low, with write enable held high. The DRAM advances its own internal row counter on each such cycle.

The refresh budget is chosen by a parameter. One setting gives 4096 cycles in 64 ms and the other gives 2048 cycles in 32 ms. Both work out to one refresh about every 15.6 µs. The timer reload value is derived from the clock rate and the chosen budget. If the arbiter holds off the request, missed refreshes pile up, to at most eight. They are then issued back to back while the grant stays high. Every strobe phase lasts a parameterised number of clocks, so the DRAM timing minimums can be met at any clock rate.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted and right after it, rasN, casN and weN are high (inactive), and refReq, busy and done are low.
- R2: With default parameters, a 250 MHz clock and the long budget, the refresh interval is 250000·64/4096 = 3906 clocks. refReq first rises exactly 3906 clock edges after reset is released.
- R3: Without a grant, refReq stays high once it has risen, and no strobe leaves its inactive level.
- R4: Each time rasN falls, casN has already been low for at least CSR_CLKS (2) clocks and weN is high.
- R5: After rasN falls, casN stays low for at least CHR_CLKS (3) clocks, and it rises back before rasN rises.
- R6: rasN stays low for at least CHR_CLKS + RAS_TAIL_CLKS (18) clocks in each refresh.
- R7: Between two refreshes, rasN stays high for at least RAS_HIGH_CLKS + PRE_CLKS (13) clocks.
- R8: done goes high for exactly one clock per completed refresh, after both strobes are back high.
- R9: The pending count saturates at MAX_PEND (8). If k intervals pass without a grant and the grant is then held, min(k, 8) refreshes run back to back, and after that refReq is low.
- R10: busy is high whenever a strobe is low, and a sequence starts only while both refReq and refGrant are high.
- R11: With the grant held high all the time, one refresh completes for each elapsed interval (8 in an 8-interval window).
- R12: If the grant is withdrawn during a refresh, that refresh completes and no further one starts. The refreshes still owed keep refReq high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| refGrant | input | 1 | Arbiter grant of the DRAM bus for refresh |
| refReq | output | 1 | Refresh owed (pending count non-zero) |
| busy | output | 1 | Refresh sequence in progress |
| done | output | 1 | One-clock pulse at the end of each refresh |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high (refresh, not test mode) |

## Verification
A wrong dwell count or a broken state order shows at the ports within the refresh in which it occurs. A strobe edge arrives too early relative to its partner, or a low or high phase is too short. A fault in the timer or in the pending counter takes longer to show: the request rises on the wrong edge, or after a delay of several intervals the drain gives the wrong number of refreshes or the request does not drop. So the bench times the first request exactly, measures every strobe phase in clocks, and drains pending backlogs of several depths, including depths beyond saturation.

// File: rtl/cbr_refresh_pkg.sv
package cbr_refresh_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CAS_SETUP,
    ST_RAS_LOW,
    ST_CAS_RELEASE,
    ST_RAS_HIGH,
    ST_PRECHARGE
  } seqState_t;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic casLow;   // drive column strobe active
    logic rasLow;   // drive row strobe active
    logic take;     // consume one pending refresh
    logic finish;   // last clock of a refresh
  } seqStrobes_t;

  function automatic int refreshInterval(input int clkKhz, input int periodMs, input int cycles);
    return (clkKhz * periodMs) / cycles;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbr_refresh_datapath.sv
module cbr_refresh_datapath
  import cbr_refresh_pkg::*;
#(
  parameter int INTERVAL = 3906,
  parameter int MAX_PEND = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  seqStrobes_t ctl,
  output logic        refReq,
  output logic        rasN,
  output logic        casN,
  output logic        weN,
  output logic        done
);

  localparam int TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam int PW = $clog2(MAX_PEND + 1);
  localparam logic [TW-1:0] RELOAD = TW'(INTERVAL - 1);
  localparam logic [PW-1:0] PEND_CAP = PW'(MAX_PEND);

  logic [TW-1:0] intervalCnt;
  logic [PW-1:0] pendCnt;
  logic          tick;

  assign tick = (intervalCnt == '0);

  // Interval timer: marks one owed refresh each INTERVAL clocks
  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalCnt <= RELOAD;
    end else if (tick) begin
      intervalCnt <= RELOAD;
    end else begin
      intervalCnt <= intervalCnt - 1'b1;
    end
  end

  // Pending counter, saturating at MAX_PEND
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendCnt <= '0;
    end else begin
      unique case ({tick, ctl.take})
        2'b10:   if (pendCnt != PEND_CAP) pendCnt <= pendCnt + 1'b1;
        2'b01:   pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  assign refReq = (pendCnt != '0);

  // Registered strobe pins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rasN <= 1'b1;
      casN <= 1'b1;
      weN  <= 1'b1;
      done <= 1'b0;
    end else begin
      rasN <= ~ctl.rasLow;
      casN <= ~ctl.casLow;
      weN  <= 1'b1;
      done <= ctl.finish;
    end
  end

  assert_pend_cap_R9: assert property (@(posedge clk) disable iff (!rstN)
    pendCnt <= PEND_CAP);

  assert_tick_raises_req_R2: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> refReq);

  assert_take_needs_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> refReq);

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> (!casN && $past(!casN) && weN));

  assert_cas_rises_first_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rasN) |-> casN);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_strobes_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (rasN && casN));

endmodule

// File: rtl/cbr_refresh_ctrl.sv
module cbr_refresh_ctrl
  import cbr_refresh_pkg::*;
#(
  parameter int CSR_CLKS      = 2,
  parameter int CHR_CLKS      = 3,
  parameter int RAS_TAIL_CLKS = 15,
  parameter int RAS_HIGH_CLKS = 1,
  parameter int PRE_CLKS      = 12
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqPending,
  input  logic        grant,
  output seqStrobes_t ctl,
  output logic        busy
);

  localparam int MAXD = maxOf(maxOf(maxOf(CSR_CLKS, CHR_CLKS), maxOf(RAS_TAIL_CLKS, RAS_HIGH_CLKS)), PRE_CLKS);
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;
  localparam logic [CW-1:0] D_CSR  = CW'(CSR_CLKS - 1);
  localparam logic [CW-1:0] D_CHR  = CW'(CHR_CLKS - 1);
  localparam logic [CW-1:0] D_TAIL = CW'(RAS_TAIL_CLKS - 1);
  localparam logic [CW-1:0] D_HIGH = CW'(RAS_HIGH_CLKS - 1);
  localparam logic [CW-1:0] D_PRE  = CW'(PRE_CLKS - 1);

  seqState_t     state, stateNext;
  logic [CW-1:0] dwell, dwellNext;
  logic          dwellDone;
  logic          mayStart;

  assign dwellDone = (dwell == '0);
  assign mayStart  = reqPending && grant;

  always_comb begin
    stateNext = state;
    dwellNext = dwellDone ? dwell : dwell - 1'b1;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (mayStart) begin
          stateNext = ST_CAS_SETUP;
          dwellNext = D_CSR;
          ctl.take  = 1'b1;
        end
      end
      ST_CAS_SETUP: begin
        ctl.casLow = 1'b1;
        if (dwellDone) begin
          stateNext = ST_RAS_LOW;
          dwellNext = D_CHR;
        end
      end
      ST_RAS_LOW: begin
        ctl.casLow = 1'b1;
        ctl.rasLow = 1'b1;
        if (dwellDone) begin
          stateNext = ST_CAS_RELEASE;
          dwellNext = D_TAIL;
        end
      end
      ST_CAS_RELEASE: begin
        ctl.rasLow = 1'b1;
        if (dwellDone) begin
          stateNext = ST_RAS_HIGH;
          dwellNext = D_HIGH;
        end
      end
      ST_RAS_HIGH: begin
        if (dwellDone) begin
          stateNext = ST_PRECHARGE;
          dwellNext = D_PRE;
        end
      end
      ST_PRECHARGE: begin
        if (dwellDone) begin
          ctl.finish = 1'b1;
          if (mayStart) begin
            stateNext = ST_CAS_SETUP;
            dwellNext = D_CSR;
            ctl.take  = 1'b1;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      dwell <= '0;
    end else begin
      state <= stateNext;
      dwell <= dwellNext;
    end
  end

  assign busy = (state != ST_IDLE);

  assert_start_granted_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(grant && reqPending));

  assert_order_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RAS_LOW) |=> (state inside {ST_RAS_LOW, ST_CAS_RELEASE}));

  assert_order_setup_R4: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CAS_SETUP) |=> (state inside {ST_CAS_SETUP, ST_RAS_LOW}));

  assert_precharge_exit_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PRECHARGE && !dwellDone) |=> (state == ST_PRECHARGE));

endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_refresh_pkg::*;
#(
  parameter int CLK_KHZ       = 250000,
  parameter bit LONG_BUDGET   = 1'b1,
  parameter int MAX_PEND      = 8,
  parameter int CSR_CLKS      = 2,
  parameter int CHR_CLKS      = 3,
  parameter int RAS_TAIL_CLKS = 15,
  parameter int RAS_HIGH_CLKS = 1,
  parameter int PRE_CLKS      = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic refGrant,
  output logic refReq,
  output logic busy,
  output logic done,
  output logic rasN,
  output logic casN,
  output logic weN
);

  localparam int BUDGET_CYCLES = LONG_BUDGET ? 4096 : 2048;
  localparam int BUDGET_MS     = LONG_BUDGET ? 64 : 32;
  localparam int INTERVAL      = refreshInterval(CLK_KHZ, BUDGET_MS, BUDGET_CYCLES);

  seqStrobes_t ctl;

  cbr_refresh_ctrl #(
    .CSR_CLKS     (CSR_CLKS),
    .CHR_CLKS     (CHR_CLKS),
    .RAS_TAIL_CLKS(RAS_TAIL_CLKS),
    .RAS_HIGH_CLKS(RAS_HIGH_CLKS),
    .PRE_CLKS     (PRE_CLKS)
  ) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .reqPending(refReq),
    .grant     (refGrant),
    .ctl       (ctl),
    .busy      (busy)
  );

  cbr_refresh_datapath #(
    .INTERVAL(INTERVAL),
    .MAX_PEND(MAX_PEND)
  ) dpInst (
    .clk   (clk),
    .rstN  (rstN),
    .ctl   (ctl),
    .refReq(refReq),
    .rasN  (rasN),
    .casN  (casN),
    .weN   (weN),
    .done  (done)
  );

  assert_idle_strobes_R10: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (rasN && casN));

endmodule

// File: tb/cbr_refresh_sched_test.sv
`timescale 1ns/1ps
module cbr_refresh_sched_test;

  localparam int INTERVAL = (250000 * 64) / 4096;   // 3906
  localparam int CSR = 2, CHR = 3, TAIL = 15, RHI = 1, PRE = 12, MAXP = 8;
  localparam int ROWS = 4;
  localparam int rowWaits [ROWS] = '{1, 3, 9, 10};
  localparam int rowExp   [ROWS] = '{1, 3, 8, 8};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic refGrant = 1'b0;
  logic refReq, busy, done, rasN, casN, weN;

  int errors = 0;
  int checks = 0;
  int doneCnt = 0;
  int rasFalls = 0;
  int casLowRun = 0, rasLowRun = 0, rasHighRun = 1000;
  logic prevRas = 1'b1, prevCas = 1'b1, prevDone = 1'b0;

  always #2 clk = ~clk;

  cbr_refresh_sched #(
    .CLK_KHZ(250000), .LONG_BUDGET(1'b1), .MAX_PEND(MAXP),
    .CSR_CLKS(CSR), .CHR_CLKS(CHR), .RAS_TAIL_CLKS(TAIL),
    .RAS_HIGH_CLKS(RHI), .PRE_CLKS(PRE)
  ) uut (
    .clk(clk), .rstN(rstN), .refGrant(refGrant), .refReq(refReq),
    .busy(busy), .done(done), .rasN(rasN), .casN(casN), .weN(weN)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Strobe monitor: phase lengths measured in clocks at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      casLowRun = 0; rasLowRun = 0; rasHighRun = 1000;
      prevRas = 1'b1; prevCas = 1'b1; prevDone = 1'b0;
    end else begin
      if (prevRas && !rasN) begin
        rasFalls++;
        check(!casN && casLowRun >= CSR, "R4 cas setup", casLowRun, CSR);
        check(weN, "R4 we high", weN, 1);
        check(rasHighRun >= RHI + PRE, "R7 precharge", rasHighRun, RHI + PRE);
        check(busy, "R10 busy", busy, 1);
      end
      if (!prevCas && casN && !rasN)
        check(rasLowRun >= CHR, "R5 cas hold", rasLowRun, CHR);
      if (!prevRas && rasN) begin
        check(rasLowRun >= CHR + TAIL, "R6 ras width", rasLowRun, CHR + TAIL);
        check(casN, "R5 cas before ras rise", casN, 1);
      end
      if (done) begin
        doneCnt++;
        check(!prevDone, "R8 done width", prevDone, 0);
        check(rasN && casN, "R8 strobes idle at done", {rasN, casN}, 3);
      end
      casLowRun  = casN ? 0 : casLowRun + 1;
      rasLowRun  = rasN ? 0 : rasLowRun + 1;
      rasHighRun = rasN ? rasHighRun + 1 : 0;
      prevRas = rasN; prevCas = casN; prevDone = done;
    end
  end

  task automatic doReset();
    refGrant = 1'b0;
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int d0, f0;
    // R1: reset state
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(rasN && casN && weN, "R1 strobes in reset", {rasN, casN, weN}, 7);
    check(!refReq && !busy && !done, "R1 flags in reset", {refReq, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(rasN && casN && weN && !refReq && !busy, "R1 after release", {rasN, casN, weN, refReq, busy}, 28);

    // R2: first request on edge INTERVAL after release
    doReset();
    repeat (INTERVAL - 1) @(posedge clk);
    @(negedge clk);
    check(!refReq, "R2 req before interval", refReq, 0);
    @(posedge clk);
    @(negedge clk);
    check(refReq, "R2 req at interval", refReq, 1);

    // R3: no grant, request sticky, strobes idle
    doReset();
    f0 = rasFalls;
    repeat (2 * INTERVAL + 5) @(posedge clk);
    @(negedge clk);
    check(refReq, "R3 sticky req", refReq, 1);
    check(rasFalls == f0 && rasN && casN, "R3 no strobes", rasFalls - f0, 0);

    // R12: grant withdrawn during a refresh
    d0 = doneCnt;
    refGrant = 1'b1;
    while (rasN) @(negedge clk);
    refGrant = 1'b0;
    repeat (100) @(negedge clk);
    check(doneCnt - d0 == 1, "R12 single refresh", doneCnt - d0, 1);
    check(refReq, "R12 req remains", refReq, 1);

    // R9: backlog table, drained under a held grant
    for (int r = 0; r < ROWS; r++) begin
      doReset();
      repeat (rowWaits[r] * INTERVAL + 10) @(posedge clk);
      @(negedge clk);
      d0 = doneCnt;
      refGrant = 1'b1;
      repeat (400) @(negedge clk);
      refGrant = 1'b0;
      check(doneCnt - d0 == rowExp[r], "R9 drain count", doneCnt - d0, rowExp[r]);
      check(!refReq && !busy, "R9 req cleared", {refReq, busy}, 0);
    end

    // R11: grant held, one refresh per interval
    doReset();
    d0 = doneCnt;
    refGrant = 1'b1;
    repeat (8 * INTERVAL + 100) @(negedge clk);
    refGrant = 1'b0;
    check(doneCnt - d0 == 8, "R11 refresh rate", doneCnt - d0, 8);

    finishRun();
  end

endmodule